// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block links an 8-bit CPU data bus to three 8-bit peripheral ports, named A, B and C, which give 24 peripheral lines in all. Port C is split into a lower nibble (bits 3..0) and an upper nibble (bits 7..4). For direction control the ports form two groups. Group A holds port A and the upper C nibble. Group B holds port B and the lower C nibble. In the basic mode each port or nibble has a fixed direction, either input or output. A control register written by the CPU sets that direction.

On the CPU side there are an active-low chip select, active-low read and write strobes, and a 2-bit select taken from the low address bits. The bidirectional data bus is split into an input, an output and an output enable, so an outside tri-state buffer can drive the real pads. Strobes are sampled on the clock. A write loads either the output latch of the selected port or the control register. A read returns the latched value or the sampled pins on the next clock. On the peripheral side each port has pins in, latch out, and a per-bit output enable.

Top module: `ppio_top`

## Requirements
- R1: After reset, all peripheral output enables are 0, all output latches are 0, every port is an input, and `bus_oe` is 0.
- R2: A write with `sel`=11 sets the direction of each port or nibble from one bit of the written byte, where 1 means input: bit 4 sets port A, bit 3 sets upper C, bit 1 sets port B and bit 0 sets lower C. Bits 7, 6, 5 and 2 are ignored. The output enable bits of a port or nibble are 1 exactly when it is an output.
- R3: A control register write clears all three output latches to zero in the same clock edge.
- R4: A write with `sel`=00, 01 or 10 loads `bus_din` into the latch of port A, B or C, in that order. The latch shows on the port's `_out` pins from the next cycle, whatever the direction.
- R5: A read with `sel`=00 or 01 returns the port latch when the port is an output, and the pins when it is an input. Pins are registered once before the read mux. A read with `sel`=10 returns latch or pins separately for each nibble, according to that nibble's direction.
- R6: A read with `sel`=11 returns the direction bits at positions 4, 3, 1 and 0, with every other bit 0.
- R7: While `cs_n` is high, strobes have no effect: no latch or direction changes, and `bus_oe` stays 0.
- R8: `bus_oe` is 1 in the cycle after a clock edge that sampled `cs_n`=0, `rd_n`=0 and `wr_n`=1, and is 0 in every other cycle.
- R9: When read and write strobes are both low under chip select, the write takes effect and the read is suppressed (`bus_oe` stays 0).
- R10: A write strobe held low over several clock edges performs a single write, using the data of its first sampled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel | input | 2 | Port/control select |
| bus_din | input | 8 | Data from CPU |
| bus_dout | output | 8 | Data to CPU |
| bus_oe | output | 1 | CPU bus drive enable |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C drive enables, upper/lower nibble |

## Verification
Two functions can land in the same cycle: a read and a write, when both strobes are sampled low under one chip select. The bench causes this in directed cases by asserting both strobes together, once against a port latch and once against the control register. It then checks that `bus_oe` stays low and that the write reached the latch or the direction bits. The random phase mixes reads, writes, pin changes and control writes, and checks every read against a bench model of latches and directions.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } ppio_sel_e;

  localparam int CTL_DIR_A  = 4;
  localparam int CTL_DIR_CU = 3;
  localparam int CTL_DIR_B  = 1;
  localparam int CTL_DIR_CL = 0;

  typedef struct packed {
    logic dir_a;
    logic dir_cu;
    logic dir_b;
    logic dir_cl;
  } ppio_dir_t;
endpackage

// File: rtl/ppio_strobe.sv
module ppio_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_fire,
  output logic rd_act
);
  logic wr_act;
  logic wr_seen;

  assign wr_act  = !cs_n && !wr_n;
  assign wr_fire = wr_act && !wr_seen;
  // write has priority over a simultaneous read
  assign rd_act  = !cs_n && !rd_n && wr_n;

  always_ff @(posedge clk) begin
    if (rst) wr_seen <= 1'b0;
    else     wr_seen <= wr_act;
  end

  a_r10_one_write_per_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !wr_fire);
endmodule

// File: rtl/ppio_port.sv
module ppio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  input  logic         dir_in,
  input  logic [W-1:0] pins,
  output logic [W-1:0] q,
  output logic [W-1:0] oe,
  output logic [W-1:0] rdata
);
  logic [W-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      pin_q <= '0;
    end else begin
      pin_q <= pins;
      if (clr)       q <= '0;
      else if (load) q <= wdata;
    end
  end

  assign oe    = {W{~dir_in}};
  assign rdata = dir_in ? pin_q : q;

  a_r4_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr) |=> $stable(q));
endmodule

// File: rtl/ppio_top.sv
module ppio_top
  import ppio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int NW = DW / 2;

  ppio_sel_e    sel_e;
  logic         wr_fire;
  logic         rd_act;
  ppio_dir_t    dir_q;
  logic         ctl_wr;
  logic [DW-1:0] rd_a, rd_b, rd_c, rd_ctl;
  logic [DW-1:0] rd_mux;

  assign sel_e  = ppio_sel_e'(sel);
  assign ctl_wr = wr_fire && (sel_e == SEL_CTRL);

  ppio_strobe u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_fire(wr_fire), .rd_act(rd_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '{dir_a: 1'b1, dir_cu: 1'b1, dir_b: 1'b1, dir_cl: 1'b1};
    end else if (ctl_wr) begin
      dir_q.dir_a  <= bus_din[CTL_DIR_A];
      dir_q.dir_cu <= bus_din[CTL_DIR_CU];
      dir_q.dir_b  <= bus_din[CTL_DIR_B];
      dir_q.dir_cl <= bus_din[CTL_DIR_CL];
    end
  end

  ppio_port #(.W(DW)) u_port_a (
    .clk(clk), .rst(rst), .load(wr_fire && sel_e == SEL_A), .clr(ctl_wr),
    .wdata(bus_din), .dir_in(dir_q.dir_a), .pins(pa_in),
    .q(pa_out), .oe(pa_oe), .rdata(rd_a)
  );

  ppio_port #(.W(DW)) u_port_b (
    .clk(clk), .rst(rst), .load(wr_fire && sel_e == SEL_B), .clr(ctl_wr),
    .wdata(bus_din), .dir_in(dir_q.dir_b), .pins(pb_in),
    .q(pb_out), .oe(pb_oe), .rdata(rd_b)
  );

  // port C: one slice per nibble, upper belongs to group A, lower to group B
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_pc
      ppio_port #(.W(NW)) u_nib (
        .clk(clk), .rst(rst), .load(wr_fire && sel_e == SEL_C), .clr(ctl_wr),
        .wdata(bus_din[g*NW +: NW]),
        .dir_in(g == 1 ? dir_q.dir_cu : dir_q.dir_cl),
        .pins(pc_in[g*NW +: NW]),
        .q(pc_out[g*NW +: NW]), .oe(pc_oe[g*NW +: NW]),
        .rdata(rd_c[g*NW +: NW])
      );
    end
  endgenerate

  always_comb begin
    rd_ctl = '0;
    rd_ctl[CTL_DIR_A]  = dir_q.dir_a;
    rd_ctl[CTL_DIR_CU] = dir_q.dir_cu;
    rd_ctl[CTL_DIR_B]  = dir_q.dir_b;
    rd_ctl[CTL_DIR_CL] = dir_q.dir_cl;
  end

  always_comb begin
    unique case (sel_e)
      SEL_A:   rd_mux = rd_a;
      SEL_B:   rd_mux = rd_b;
      SEL_C:   rd_mux = rd_c;
      default: rd_mux = rd_ctl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      bus_oe   <= rd_act;
      bus_dout <= rd_act ? rd_mux : '0;
    end
  end

  a_r3_ctrl_write_clears: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));
  a_r7_no_cs_no_change: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable({pa_out, pb_out, pc_out}) && $stable(dir_q) && !bus_oe));
  a_r8_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(!cs_n && !rd_n && wr_n));
  a_r9_write_beats_read: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && !wr_n) |=> !bus_oe);
endmodule

// File: tb/ppio_top_bench.sv
module ppio_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_run = 0;
  int n_fail = 0;

  // bench model
  logic m_da = 1, m_dcu = 1, m_db = 1, m_dcl = 1;
  logic [7:0] m_la = 0, m_lb = 0, m_lc = 0;

  always #4 clk = ~clk;

  ppio_top u_ppio_top (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] s);
    case (s)
      2'b00: return m_da ? pa_in : m_la;
      2'b01: return m_db ? pb_in : m_lb;
      2'b10: return {m_dcu ? pc_in[7:4] : m_lc[7:4], m_dcl ? pc_in[3:0] : m_lc[3:0]};
      default: return {3'b000, m_da, m_dcu, 1'b0, m_db, m_dcl};
    endcase
  endfunction

  function automatic logic [23:0] exp_oe();
    return {{8{~m_da}}, {8{~m_db}}, {~{4{m_dcu}}}, {~{4{m_dcl}}}};
  endfunction

  task automatic model_write(input logic [1:0] s, input logic [7:0] d);
    case (s)
      2'b00: m_la = d;
      2'b01: m_lb = d;
      2'b10: m_lc = d;
      default: begin
        m_da = d[4]; m_dcu = d[3]; m_db = d[1]; m_dcl = d[0];
        m_la = 0; m_lb = 0; m_lc = 0;
      end
    endcase
  endtask

  task automatic cpu_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; sel = s; bus_din = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    model_write(s, d);
  endtask

  task automatic check_outputs(input string req);
    check(req, {pa_out, pb_out, pc_out}, {m_la, m_lb, m_lc});
    check(req, {pa_oe, pb_oe, pc_oe}, exp_oe());
  endtask

  task automatic cpu_read(input logic [1:0] s, input string req);
    logic [7:0] e;
    @(negedge clk);
    cs_n = 0; rd_n = 0; sel = s;
    e = exp_read(s);
    @(negedge clk);
    check(req, {bus_oe, bus_dout}, {1'b1, e});
    cs_n = 1; rd_n = 1;
    @(negedge clk);
    check("R8", bus_oe, 1'b0);
  endtask

  task automatic set_pins(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk);
    pa_in = a; pb_in = b; pc_in = c;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", {pa_out, pb_out, pc_out}, 24'h0);
    check("R1", {pa_oe, pb_oe, pc_oe}, 24'h0);
    check("R1", bus_oe, 1'b0);
    cpu_read(2'b11, "R6 reset ctrl");

    // R2/R3: set all outputs, check ignored bits
    cpu_write(2'b00, 8'h5A);
    cpu_write(2'b11, 8'hE4);
    check_outputs("R2 R3");
    cpu_read(2'b11, "R6");

    // R4: latch loads
    cpu_write(2'b00, 8'hA5);
    cpu_write(2'b01, 8'h3C);
    cpu_write(2'b10, 8'h96);
    check_outputs("R4");
    cpu_read(2'b00, "R5 out A");
    cpu_read(2'b10, "R5 out C");

    // R5 mixed port C: upper input, lower output
    cpu_write(2'b11, 8'h08);
    cpu_write(2'b10, 8'h7E);
    set_pins(8'h11, 8'h22, 8'hC3);
    cpu_read(2'b10, "R5 mixed C");
    cpu_write(2'b11, 8'h01);
    cpu_write(2'b10, 8'h7E);
    cpu_read(2'b10, "R5 mixed C lower in");
    check_outputs("R2 mixed");

    // R7: strobes without chip select
    @(negedge clk);
    cs_n = 1; wr_n = 0; rd_n = 0; sel = 2'b10; bus_din = 8'hFF;
    @(negedge clk);
    check("R7 oe", bus_oe, 1'b0);
    sel = 2'b11; bus_din = 8'h00;
    @(negedge clk);
    wr_n = 1; rd_n = 1;
    check_outputs("R7");

    // R9: read and write together
    @(negedge clk);
    cs_n = 0; wr_n = 0; rd_n = 0; sel = 2'b10; bus_din = 8'h42;
    @(negedge clk);
    check("R9 oe", bus_oe, 1'b0);
    cs_n = 1; wr_n = 1; rd_n = 1;
    model_write(2'b10, 8'h42);
    check_outputs("R9 port");
    @(negedge clk);
    cs_n = 0; wr_n = 0; rd_n = 0; sel = 2'b11; bus_din = 8'h12;
    @(negedge clk);
    check("R9 oe ctrl", bus_oe, 1'b0);
    cs_n = 1; wr_n = 1; rd_n = 1;
    model_write(2'b11, 8'h12);
    check_outputs("R9 ctrl");

    // R10: held write strobe, data changes
    @(negedge clk);
    cs_n = 0; wr_n = 0; sel = 2'b01; bus_din = 8'h81;
    @(negedge clk);
    bus_din = 8'h18;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    model_write(2'b01, 8'h81);
    check_outputs("R10");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [1:0] s;
        s = 2'($urandom_range(0, 2));
        cpu_write(s, 8'($urandom));
        check_outputs("R4 rand");
      end else if (op == 4) begin
        cpu_write(2'b11, 8'($urandom));
        check_outputs("R2 R3 rand");
      end else if (op < 7) begin
        set_pins(8'($urandom), 8'($urandom), 8'($urandom));
      end else begin
        logic [1:0] s;
        s = 2'($urandom_range(0, 3));
        cpu_read(s, "R5 R6 rand");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule